// File: doc/BRIEF.md
# Basic Bit-Manipulation Execution Unit

This unit is a purely combinational execution stage for a 64-bit integer core. It covers the basic bit-manipulation group: bit counting, inverted logic ops, signed and unsigned min/max, byte/half sign- and zero-extension, rotates, byte reversal and a per-byte OR-combine. It also offers "word" forms that act on the low 32 bits of the operand. The core's decoder supplies a small operation code. The register file supplies two operands and a 6-bit immediate amount. The result appears in the same cycle.

Two control inputs gate legality. An extension-enable bit must be high for any operation to be accepted. A mode bit must be high for the word forms to be accepted. A rejected or unknown operation raises the illegal flag and forces the result to zero, so nothing stale can leak into a write-back.

Top module: `bmu_alu`

## Requirements
- R1: While `ext_en_i` is low, every operation drives `illegal_o` high and `result_o` to zero.
- R2: The word opcodes 18..23 are illegal (flag high, result zero) while `mode64_i` is low. Opcodes 24..31 are always illegal.
- R3: Opcode 0 counts leading zeros and opcode 1 counts trailing zeros over 64 bits; a zero operand gives 64. Opcodes 18 and 19 do the same within the low 32 bits only, give 32 for a zero low word, and zero-extend the count.
- R4: Opcode 2 returns the number of set bits of the 64-bit operand. Opcode 20 returns the number of set bits in the low 32 bits only.
- R5: Opcode 3 returns a AND NOT b, opcode 4 returns a OR NOT b, and opcode 5 returns NOT (a XOR b).
- R6: Opcodes 6/7 return the two's-complement minimum/maximum of a and b. Opcodes 8/9 return the unsigned minimum/maximum.
- R7: Opcode 10 sign-extends bit 7 and opcode 11 sign-extends bit 15 over the upper bits. Opcode 12 keeps bits 15..0 and clears bits 63..16.
- R8: Opcode 13 rotates a left by b[5:0], opcode 14 rotates a right by b[5:0], and opcode 15 rotates a right by `imm_i`. An amount of zero returns a unchanged.
- R9: Opcodes 21 (left, by b[4:0]), 22 (right, by b[4:0]) and 23 (right, by imm[4:0]) rotate a[31:0]. The 32-bit result is then sign-extended to 64 bits.
- R10: Opcode 16 returns the operand with its eight bytes in reverse order.
- R11: Opcode 17 sets each result byte to 0xFF when the matching byte of a is nonzero, and to 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand or rotate amount |
| imm_i | input | 6 | Immediate rotate amount |
| op_i | input | 5 | Operation code |
| ext_en_i | input | 1 | Extension enable; low rejects all operations |
| mode64_i | input | 1 | High when the core runs in 64-bit mode; gates the word forms |
| result_o | output | 64 | Operation result, zero when illegal |
| illegal_o | output | 1 | High when the operation is rejected |

## Verification
The unit holds no state, so any fault in the internal selection or counting logic shows at the ports in the same cycle as the operand that exposes it. A priority error in a counter is seen only on operands with several set bits, or with a zero operand, so the vectors mix single-bit, multi-bit and all-zero operands. The mix of a and b amounts matters for rotates: a mistake in amount selection or truncation shows only when the immediate and register amounts differ, or when the register amount exceeds the field width. A fault in the word sign extension shows only when bit 31 of the rotated value is set.

// File: rtl/bmu_pkg.sv
// Package: shared operation codes for the bit-manipulation unit.
// Assumes a 5-bit operation field; codes 24..31 are unassigned.
package bmu_pkg;

    typedef enum logic [4:0] {
        OP_CLZ   = 5'd0,
        OP_CTZ   = 5'd1,
        OP_CPOP  = 5'd2,
        OP_ANDN  = 5'd3,
        OP_ORN   = 5'd4,
        OP_XNOR  = 5'd5,
        OP_MIN   = 5'd6,
        OP_MAX   = 5'd7,
        OP_MINU  = 5'd8,
        OP_MAXU  = 5'd9,
        OP_SEXTB = 5'd10,
        OP_SEXTH = 5'd11,
        OP_ZEXTH = 5'd12,
        OP_ROL   = 5'd13,
        OP_ROR   = 5'd14,
        OP_RORI  = 5'd15,
        OP_REV8  = 5'd16,
        OP_ORCB  = 5'd17,
        OP_CLZW  = 5'd18,
        OP_CTZW  = 5'd19,
        OP_CPOPW = 5'd20,
        OP_ROLW  = 5'd21,
        OP_RORW  = 5'd22,
        OP_RORIW = 5'd23
    } bmu_op_e;

    localparam logic [4:0] OP_LAST_LEGAL = 5'd23;
    localparam logic [4:0] OP_FIRST_WORD = 5'd18;

endpackage

// File: rtl/bmu_bitcount.sv
// Module: leading-zero, trailing-zero and set-bit counts of a W-bit vector.
// Assumes W is a power of two; an all-zero vector yields W for both zero counts.
module bmu_bitcount #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] lead_o,
    output logic [CW-1:0] trail_o,
    output logic [CW-1:0] ones_o
);

    // Leading zeros: the highest set bit wins because it is visited last.
    always_comb begin
        lead_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) lead_o = CW'(W - 1 - i);
        end
    end

    // Trailing zeros: the lowest set bit wins because it is visited last.
    always_comb begin
        trail_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) trail_o = CW'(i);
        end
    end

    // Population count: plain sum of all bits.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/bmu_rotate.sv
// Module: W-bit rotator, left or right, by an amount taken modulo W.
// Assumes W is a power of two; a left rotate is done as a right rotate by -amt.
module bmu_rotate #(
    parameter int W  = 64,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    input  logic          left_i,
    output logic [W-1:0]  rot_o
);

    logic [AW-1:0] right_amt;

    // Convert the direction into a single right-rotate amount.
    always_comb begin
        right_amt = left_i ? (~amt_i + AW'(1)) : amt_i;
    end

    // Right rotate through a doubled copy of the data.
    always_comb begin
        rot_o = W'({data_i, data_i} >> right_amt);
    end

endmodule

// File: rtl/bmu_logic.sv
// Module: inverted logic ops, min/max, extensions, byte reverse, OR-combine.
// Assumes XLEN is a multiple of 8 and at least 16; returns zero for other opcodes.
module bmu_logic
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NB   = XLEN / 8
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  bmu_op_e         op_i,
    output logic [XLEN-1:0] res_o
);

    logic [XLEN-1:0] rev;
    logic [XLEN-1:0] orc;
    logic            s_lt;
    logic            u_lt;

    // Per-byte structure: reversal and OR-combine.
    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign rev[8*g +: 8] = a_i[8*(NB-1-g) +: 8];
        assign orc[8*g +: 8] = {8{|a_i[8*g +: 8]}};
    end

    // Comparisons shared by min and max.
    always_comb begin
        s_lt = $signed(a_i) < $signed(b_i);
        u_lt = a_i < b_i;
    end

    // Result select for this unit's opcodes.
    always_comb begin
        case (op_i)
            OP_ANDN:  res_o = a_i & ~b_i;
            OP_ORN:   res_o = a_i | ~b_i;
            OP_XNOR:  res_o = ~(a_i ^ b_i);
            OP_MIN:   res_o = s_lt ? a_i : b_i;
            OP_MAX:   res_o = s_lt ? b_i : a_i;
            OP_MINU:  res_o = u_lt ? a_i : b_i;
            OP_MAXU:  res_o = u_lt ? b_i : a_i;
            OP_SEXTB: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
            OP_SEXTH: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
            OP_ZEXTH: res_o = {{(XLEN-16){1'b0}}, a_i[15:0]};
            OP_REV8:  res_o = rev;
            OP_ORCB:  res_o = orc;
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/bmu_alu.sv
// Module: top of the bit-manipulation execution unit, single-cycle combinational.
// Assumes decode has produced op_i; word forms act on the low WLEN bits.
module bmu_alu
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int XAW  = $clog2(XLEN),
    parameter int WAW  = $clog2(WLEN)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XAW-1:0]  imm_i,
    input  logic [4:0]      op_i,
    input  logic            ext_en_i,
    input  logic            mode64_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);

    localparam int XCW = XAW + 1;
    localparam int WCW = WAW + 1;

    bmu_op_e         op;
    logic [XCW-1:0]  lz_x, tz_x, pc_x;
    logic [WCW-1:0]  lz_w, tz_w, pc_w;
    logic [XLEN-1:0] rot_x;
    logic [WLEN-1:0] rot_w;
    logic [XAW-1:0]  amt_x;
    logic [WAW-1:0]  amt_w;
    logic            rot_left;
    logic [XLEN-1:0] logic_res;
    logic            is_word;
    logic            known_op;
    logic [XLEN-1:0] raw_res;

    // Opcode typing and rotate controls.
    always_comb begin
        op       = bmu_op_e'(op_i);
        rot_left = (op == OP_ROL) || (op == OP_ROLW);
        amt_x    = (op == OP_RORI)  ? imm_i : b_i[XAW-1:0];
        amt_w    = (op == OP_RORIW) ? imm_i[WAW-1:0] : b_i[WAW-1:0];
    end

    bmu_bitcount #(.W(XLEN)) u_cnt_x (
        .vec_i   (a_i),
        .lead_o  (lz_x),
        .trail_o (tz_x),
        .ones_o  (pc_x)
    );

    bmu_bitcount #(.W(WLEN)) u_cnt_w (
        .vec_i   (a_i[WLEN-1:0]),
        .lead_o  (lz_w),
        .trail_o (tz_w),
        .ones_o  (pc_w)
    );

    bmu_rotate #(.W(XLEN)) u_rot_x (
        .data_i (a_i),
        .amt_i  (amt_x),
        .left_i (rot_left),
        .rot_o  (rot_x)
    );

    bmu_rotate #(.W(WLEN)) u_rot_w (
        .data_i (a_i[WLEN-1:0]),
        .amt_i  (amt_w),
        .left_i (rot_left),
        .rot_o  (rot_w)
    );

    bmu_logic #(.XLEN(XLEN)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op),
        .res_o (logic_res)
    );

    // Legality: extension enabled, opcode assigned, word forms only in 64-bit mode.
    always_comb begin
        known_op  = op_i <= OP_LAST_LEGAL;
        is_word   = known_op && (op_i >= OP_FIRST_WORD);
        illegal_o = !ext_en_i || !known_op || (is_word && !mode64_i);
    end

    // Result select across the sub-units.
    always_comb begin
        case (op)
            OP_CLZ:   raw_res = XLEN'(lz_x);
            OP_CTZ:   raw_res = XLEN'(tz_x);
            OP_CPOP:  raw_res = XLEN'(pc_x);
            OP_CLZW:  raw_res = XLEN'(lz_w);
            OP_CTZW:  raw_res = XLEN'(tz_w);
            OP_CPOPW: raw_res = XLEN'(pc_w);
            OP_ROL, OP_ROR, OP_RORI:
                      raw_res = rot_x;
            OP_ROLW, OP_RORW, OP_RORIW:
                      raw_res = {{(XLEN-WLEN){rot_w[WLEN-1]}}, rot_w};
            default:  raw_res = logic_res;
        endcase
    end

    // Squash the result of a rejected operation.
    always_comb begin
        result_o = illegal_o ? '0 : raw_res;
    end

endmodule

// File: rtl/bmu_alu_chk.sv
// Module: port-level checker for bmu_alu, attached by bind.
// Assumes purely combinational behaviour; checks run whenever ports settle.
module bmu_alu_chk #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input logic [XLEN-1:0] a_i,
    input logic [XLEN-1:0] b_i,
    input logic [4:0]      op_i,
    input logic            ext_en_i,
    input logic            mode64_i,
    input logic [XLEN-1:0] result_o,
    input logic            illegal_o
);

    // Immediate checks of the port relations.
    always_comb begin
        if (!ext_en_i) begin
            assert_disabled_R1: assert (illegal_o && (result_o == '0));
        end
        if (op_i >= 5'd18 && !mode64_i) begin
            assert_word_gate_R2: assert (illegal_o && (result_o == '0));
        end
        if (!illegal_o && op_i == 5'd0 && a_i == '0) begin
            assert_clz_zero_R3: assert (result_o == XLEN'(XLEN));
        end
        if (!illegal_o && op_i == 5'd2) begin
            assert_pop_bound_R4: assert (result_o <= XLEN'(XLEN));
        end
        if (!illegal_o && op_i >= 5'd6 && op_i <= 5'd9) begin
            assert_minmax_pick_R6: assert ((result_o == a_i) || (result_o == b_i));
        end
        if (!illegal_o && op_i >= 5'd21 && op_i <= 5'd23) begin
            assert_word_sext_R9: assert (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}});
        end
        if (!illegal_o && op_i == 5'd17) begin
            for (int i = 0; i < XLEN / 8; i++) begin
                assert_orc_byte_R11: assert ((result_o[8*i +: 8] == 8'h00) || (result_o[8*i +: 8] == 8'hFF));
            end
        end
    end

endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .op_i      (op_i),
    .ext_en_i  (ext_en_i),
    .mode64_i  (mode64_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/bmu_alu_bench.sv
// Bench: scoreboard for bmu_alu. A driver task applies operands after a rising
// edge and queues the expected result; a monitor compares on the falling edge.
module bmu_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [63:0] a, b;
    logic [5:0]  imm;
    logic [4:0]  op;
    logic        en, m64;
    logic [63:0] res;
    logic        ill;

    int checks;
    int errors;
    bit done;

    logic [63:0] q_res[$];
    logic        q_ill[$];
    string       q_tag[$];

    bmu_alu u_bmu_alu (
        .a_i       (a),
        .b_i       (b),
        .imm_i     (imm),
        .op_i      (op),
        .ext_en_i  (en),
        .mode64_i  (m64),
        .result_o  (res),
        .illegal_o (ill)
    );

    // Free-running clock.
    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Driver: apply one operation and queue its expected outcome.
    task automatic drive(input logic [4:0] o, input logic [63:0] va, input logic [63:0] vb,
                         input logic [5:0] vi, input logic e, input logic m,
                         input logic [63:0] exp_res, input logic exp_ill, input string tag);
        @(posedge clk);
        #1;
        op = o; a = va; b = vb; imm = vi; en = e; m64 = m;
        q_res.push_back(exp_res);
        q_ill.push_back(exp_ill);
        q_tag.push_back(tag);
    endtask

    // Shorthand for a legal operation in 64-bit mode.
    task automatic ok(input logic [4:0] o, input logic [63:0] va, input logic [63:0] vb,
                      input logic [5:0] vi, input logic [63:0] exp_res, input string tag);
        drive(o, va, vb, vi, 1'b1, 1'b1, exp_res, 1'b0, tag);
    endtask

    // Monitor: pop and compare on the falling edge.
    always @(negedge clk) begin
        if (q_res.size() > 0) begin
            logic [63:0] er;
            logic        ei;
            string       tg;
            er = q_res.pop_front();
            ei = q_ill.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (res !== er || ill !== ei) begin
                errors++;
                $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                         tg, res, ill, er, ei);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        checks = 0; errors = 0;
        rst_n = 1'b0; op = '0; a = '0; b = '0; imm = '0; en = 1'b0; m64 = 1'b1;
        // Reset state: extension disabled, unit must reject (R1).
        drive(5'd0, 64'h0, 64'h0, 6'd0, 1'b0, 1'b1, 64'h0, 1'b1, "R1 reset state");
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        drive(5'd3, 64'hFFFF, 64'h0, 6'd0, 1'b0, 1'b1, 64'h0, 1'b1, "R1 andn disabled");
        drive(5'd21, 64'h1, 64'h1, 6'd0, 1'b0, 1'b1, 64'h0, 1'b1, "R1 rolw disabled");

        // R2: word forms gated by mode, unassigned opcodes.
        drive(5'd18, 64'h1, 64'h0, 6'd0, 1'b1, 1'b0, 64'h0, 1'b1, "R2 clzw in 32-bit mode");
        drive(5'd23, 64'h1, 64'h0, 6'd4, 1'b1, 1'b0, 64'h0, 1'b1, "R2 roriw in 32-bit mode");
        drive(5'd31, 64'h1, 64'h0, 6'd0, 1'b1, 1'b1, 64'h0, 1'b1, "R2 opcode 31");
        drive(5'd0, 64'h1, 64'h0, 6'd0, 1'b1, 1'b0, 64'd63, 1'b0, "R2 full clz in 32-bit mode");

        // R3: zero counts.
        ok(5'd0, 64'h0, 64'h0, 6'd0, 64'd64, "R3 clz zero");
        ok(5'd0, 64'h0000_0000_0001_0000, 64'h0, 6'd0, 64'd47, "R3 clz bit16");
        ok(5'd0, 64'h8000_0000_0000_0001, 64'h0, 6'd0, 64'd0, "R3 clz top bit");
        ok(5'd1, 64'h0000_0000_0001_0000, 64'h0, 6'd0, 64'd16, "R3 ctz bit16");
        ok(5'd1, 64'h0, 64'h0, 6'd0, 64'd64, "R3 ctz zero");
        ok(5'd1, 64'hC000_0000_0000_0100, 64'h0, 6'd0, 64'd8, "R3 ctz multi");
        ok(5'd18, 64'hFFFF_FFFF_0000_0000, 64'h0, 6'd0, 64'd32, "R3 clzw zero low word");
        ok(5'd18, 64'hFFFF_0000_0000_8000, 64'h0, 6'd0, 64'd16, "R3 clzw bit15");
        ok(5'd19, 64'h0000_0001_0000_0000, 64'h0, 6'd0, 64'd32, "R3 ctzw zero low word");
        ok(5'd19, 64'h0000_0001_0000_0040, 64'h0, 6'd0, 64'd6, "R3 ctzw bit6");

        // R4: population counts.
        ok(5'd2, 64'hF0F0_0000_0000_0001, 64'h0, 6'd0, 64'd9, "R4 cpop");
        ok(5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0, 64'd64, "R4 cpop all ones");
        ok(5'd20, 64'hF0F0_0000_0000_0001, 64'h0, 6'd0, 64'd1, "R4 cpopw low only");

        // R5: inverted logic.
        ok(5'd3, 64'hFF00, 64'h0F0F, 6'd0, 64'hF000, "R5 andn");
        ok(5'd4, 64'h0, 64'hFFFF_FFFF_FFFF_0000, 6'd0, 64'hFFFF, "R5 orn");
        ok(5'd5, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 6'd0, 64'h0, "R5 xnor differ");
        ok(5'd5, 64'h1234, 64'h1234, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R5 xnor equal");

        // R6: min/max signed and unsigned.
        ok(5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 min signed");
        ok(5'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 64'h1, "R6 max signed");
        ok(5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 64'h1, "R6 min unsigned");
        ok(5'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 max unsigned");

        // R7: extensions.
        ok(5'd10, 64'h1234_0080, 64'h0, 6'd0, 64'hFFFF_FFFF_FFFF_FF80, "R7 sext byte");
        ok(5'd11, 64'hFFFF_0000_0000_7FFF, 64'h0, 6'd0, 64'h7FFF, "R7 sext half");
        ok(5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0, 64'hFFFF, "R7 zext half");

        // R8: full-width rotates.
        ok(5'd13, 64'h8000_0000_0000_0001, 64'd1, 6'd0, 64'h3, "R8 rol by 1");
        ok(5'd14, 64'h1, 64'd4, 6'd0, 64'h1000_0000_0000_0000, "R8 ror by 4");
        ok(5'd14, 64'h1234, 64'd64, 6'd0, 64'h1234, "R8 ror amount wraps to zero");
        ok(5'd15, 64'hAB, 64'd3, 6'd8, 64'hAB00_0000_0000_0000, "R8 rori uses immediate");

        // R9: word rotates with sign extension.
        ok(5'd22, 64'hFFFF_FFFF_0000_0001, 64'd1, 6'd0, 64'hFFFF_FFFF_8000_0000, "R9 rorw");
        ok(5'd21, 64'h4000_0000, 64'd33, 6'd0, 64'hFFFF_FFFF_8000_0000, "R9 rolw low five bits");
        ok(5'd23, 64'h1234_5678, 64'd0, 6'd36, 64'hFFFF_FFFF_8123_4567, "R9 roriw");
        ok(5'd21, 64'hFFFF_FFFF_0000_0001, 64'd0, 6'd0, 64'h1, "R9 rolw zero amount");

        // R10: byte reverse.
        ok(5'd16, 64'h0102_0304_0506_0708, 64'h0, 6'd0, 64'h0807_0605_0403_0201, "R10 rev8");

        // R11: OR-combine.
        ok(5'd17, 64'h0001_0000_8000_0100, 64'h0, 6'd0, 64'h00FF_0000_FF00_FF00, "R11 orc.b");
        ok(5'd17, 64'h0, 64'h0, 6'd0, 64'h0, "R11 orc.b zero");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule